// File: doc/BRIEF.md
# CRT Vertical Sync End and Retrace Interrupt Control

This block is one slice of a CRT display controller. It holds the vertical sync end control register, which carries three functions. One is a write lock for the eight low timing registers. One is the enable and release controls for a retrace event latch. The last is a 4-bit field that ends the vertical sync pulse. The register is reached by indexed writes: an index byte and a data byte arrive together with a write strobe. The register answers at index 11h.

The block keeps two shadow copies of the register, one for each display pipeline. A pipeline-select input chooses the copy that is written and read back. The same copy also governs protection, sync end matching and the retrace latch. From the current scanline and a sync start value, the block forms the vertical sync pulse. It also produces a per-index write-enable mask for timing registers 00h to 07h, and a pending flag that software polls as a status bit. There is no interrupt line.

Top module: `crtc_vsync_irq`

## Requirements
- R1: A write with index 11h stores the data in the shadow copy picked by `pipe_sel_i` (0 = pipeline A, 1 = pipeline B). The other copy keeps its value. `rd_data_o` always shows the selected copy.
- R2: Bit 6 of the register ignores writes and always reads back as 0.
- R3: After reset, both copies hold 00h, `vsync_o` is 0, `pend_o` is 0 and the write-enable mask is 0.
- R4: `timing_we_o[i]` is 1 only in a write cycle with index i (0 to 7) and only while bit 7 of the active copy is 0. Bit 7 = 1 blocks every bit of the mask. Writes to any other index leave the mask at 0.
- R5: `ovf_b4_we_o` is 1 in every write cycle with index 07h, whatever the state of bit 7.
- R6: `vsync_o` rises one clock after a cycle in which `scanline_i` equals `vs_start_i` while the pulse is low.
- R7: `vsync_o` falls one clock after the first later scanline whose low 4 bits equal bits 3:0 of the active copy. The pulse therefore lasts ((end − start) mod 16) lines, and 16 lines when that difference is 0.
- R8: A rising edge of `vsync_o` sets `pend_o` one clock later when bit 5 is 0 and bit 4 is 1.
- R9: While bit 5 is 1, no retrace edge sets `pend_o`.
- R10: While bit 4 is 0, `pend_o` is cleared and held at 0. Clearing wins over a same-cycle set. A new event latches only after bit 4 is written back to 1.
- R11: Protection, sync end matching and the retrace latch all use the copy picked by `pipe_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 8 | Register index of the write |
| wr_data_i | input | 8 | Write data |
| pipe_sel_i | input | 1 | Shadow copy / pipeline select |
| rd_data_o | output | 8 | Readback of the selected copy |
| scanline_i | input | LINE_W | Current scanline count |
| vs_start_i | input | LINE_W | Vertical sync start scanline |
| vsync_o | output | 1 | Vertical sync pulse |
| timing_we_o | output | 8 | Write enables for timing indices 00h to 07h |
| ovf_b4_we_o | output | 1 | Write enable for bit 4 of index 07h |
| pend_o | output | 1 | Retrace pending status bit |

## Verification
The assertions assume that `scanline_i` stays on one line for several clocks and then steps by one. They also assume that `vs_start_i` and `pipe_sel_i` change only while no sync pulse is running. If either assumption fails, a pulse edge cannot be tied to a single start or end line. The stimulus keeps to this. Each line is held for four clocks. The sync start value is loaded while the scanline is below it. The pipeline select changes only between complete frames.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned END_W     = 4;
  localparam int unsigned NUM_TIMING = 8;
  localparam logic [7:0]  VSEND_IDX = 8'h11;
  localparam logic [7:0]  OVF_IDX   = 8'h07;

  typedef struct packed {
    logic             prot;       // 1: lock timing indices 00h-07h
    logic             rsvd;       // always 0
    logic             irq_off;    // 1: no new retrace events
    logic             irq_clr_n;  // 0: clear and hold pending
    logic [END_W-1:0] vs_end;
  } vsend_reg_t;
endpackage

// File: rtl/crtc_shadow_regs.sv
module crtc_shadow_regs
  import crtc_pkg::*;
#(
  parameter int unsigned NUM_COPIES = 2,
  localparam int unsigned SEL_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output vsend_reg_t        act_o
);
  vsend_reg_t copy_q [NUM_COPIES];
  vsend_reg_t wr_val;

  always_comb begin
    wr_val      = vsend_reg_t'(wr_data_i);
    wr_val.rsvd = 1'b0;
  end

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        copy_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == VSEND_IDX && sel_i == SEL_W'(g))
        copy_q[g] <= wr_val;
    end
  end

  assign act_o = copy_q[sel_i];
endmodule

// File: rtl/crtc_prot_gate.sv
module crtc_prot_gate
  import crtc_pkg::*;
(
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_idx_i,
  input  logic                  prot_i,
  output logic [NUM_TIMING-1:0] timing_we_o,
  output logic                  ovf_b4_we_o
);
  for (genvar i = 0; i < NUM_TIMING; i++) begin : g_we
    assign timing_we_o[i] = wr_en_i && !prot_i && (wr_idx_i == 8'(i));
  end

  // bit 4 of the overflow register bypasses the lock
  assign ovf_b4_we_o = wr_en_i && (wr_idx_i == OVF_IDX);
endmodule

// File: rtl/crtc_vsync_gen.sv
module crtc_vsync_gen
  import crtc_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] start_i,
  input  logic [END_W-1:0]  end_i,
  output logic              vs_o
);
  logic              vs_q;
  logic [LINE_W-1:0] first_q;
  logic              hit_start, hit_end;

  assign hit_start = (line_i == start_i);
  // end matches only on a scanline later than the one that started the pulse
  assign hit_end   = (line_i[END_W-1:0] == end_i) && (line_i != first_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      first_q <= '0;
    end else if (!vs_q) begin
      if (hit_start) begin
        vs_q    <= 1'b1;
        first_q <= line_i;
      end
    end else if (hit_end) begin
      vs_q <= 1'b0;
    end
  end

  assign vs_o = vs_q;
endmodule

// File: rtl/crtc_retrace_latch.sv
module crtc_retrace_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_i,
  input  logic irq_off_i,
  input  logic irq_clr_n_i,
  output logic pend_o
);
  logic vs_d, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_d   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_d <= vs_i;
      if (!irq_clr_n_i)
        pend_q <= 1'b0;
      else if (vs_i && !vs_d && !irq_off_i)
        pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/crtc_vsync_irq.sv
module crtc_vsync_irq
  import crtc_pkg::*;
#(
  parameter int unsigned LINE_W    = 11,
  parameter int unsigned NUM_PIPES = 2,
  localparam int unsigned SEL_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_idx_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [SEL_W-1:0]      pipe_sel_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [LINE_W-1:0]     scanline_i,
  input  logic [LINE_W-1:0]     vs_start_i,
  output logic                  vsync_o,
  output logic [NUM_TIMING-1:0] timing_we_o,
  output logic                  ovf_b4_we_o,
  output logic                  pend_o
);
  vsend_reg_t act_reg;

  crtc_shadow_regs #(.NUM_COPIES(NUM_PIPES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .sel_i     (pipe_sel_i),
    .act_o     (act_reg)
  );

  crtc_prot_gate u_prot (
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .prot_i      (act_reg.prot),
    .timing_we_o (timing_we_o),
    .ovf_b4_we_o (ovf_b4_we_o)
  );

  crtc_vsync_gen #(.LINE_W(LINE_W)) u_vs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (scanline_i),
    .start_i (vs_start_i),
    .end_i   (act_reg.vs_end),
    .vs_o    (vsync_o)
  );

  crtc_retrace_latch u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vs_i        (vsync_o),
    .irq_off_i   (act_reg.irq_off),
    .irq_clr_n_i (act_reg.irq_clr_n),
    .pend_o      (pend_o)
  );

  assign rd_data_o = act_reg;
endmodule

// File: rtl/crtc_vsync_irq_chk.sv
module crtc_vsync_irq_chk
  import crtc_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [7:0]            wr_idx_i,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic [LINE_W-1:0]     scanline_i,
  input logic [LINE_W-1:0]     vs_start_i,
  input logic                  vsync_o,
  input logic [NUM_TIMING-1:0] timing_we_o,
  input logic                  ovf_b4_we_o,
  input logic                  pend_o,
  input vsend_reg_t            act_reg
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[6] == 1'b0); // R2

  AST_PROT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_reg.prot |-> timing_we_o == '0); // R4

  AST_OVF_B4_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == OVF_IDX) |-> ovf_b4_we_o); // R5

  AST_SYNC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vsync_o && scanline_i == vs_start_i) |=> vsync_o); // R6

  AST_SYNC_FALL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_o) |-> $past(scanline_i[END_W-1:0]) == $past(act_reg.vs_end)); // R7

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vsync_o) && !act_reg.irq_off && act_reg.irq_clr_n) |=> pend_o); // R8

  AST_PEND_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_reg.irq_off && !pend_o) |=> !pend_o); // R9

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_reg.irq_clr_n |=> !pend_o); // R10
endmodule

bind crtc_vsync_irq crtc_vsync_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .rd_data_o   (rd_data_o),
  .scanline_i  (scanline_i),
  .vs_start_i  (vs_start_i),
  .vsync_o     (vsync_o),
  .timing_we_o (timing_we_o),
  .ovf_b4_we_o (ovf_b4_we_o),
  .pend_o      (pend_o),
  .act_reg     (act_reg)
);

// File: tb/sim_crtc_vsync_irq.sv
module sim_crtc_vsync_irq;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_idx = '0;
  logic [7:0]    wr_data = '0;
  logic          sel = 1'b0;
  logic [7:0]    rd_data;
  logic [LW-1:0] line = '0;
  logic [LW-1:0] vs_start = 11'd1000;
  logic          vsync;
  logic [7:0]    twe;
  logic          b4we;
  logic          pend;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the sync pulse
  bit            vs_m = 0;
  logic [LW-1:0] first_m = '0;

  always #2.5 clk = ~clk;

  crtc_vsync_irq #(.LINE_W(LW), .NUM_PIPES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .pipe_sel_i(sel), .rd_data_o(rd_data),
    .scanline_i(line), .vs_start_i(vs_start), .vsync_o(vsync),
    .timing_we_o(twe), .ovf_b4_we_o(b4we), .pend_o(pend)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // one-cycle write; returns the comb enables seen during the write cycle
  task automatic wr(input logic [7:0] idx, input logic [7:0] d,
                    output logic [7:0] we_seen, output logic b4_seen);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    #1;
    we_seen = twe; b4_seen = b4we;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 8'h00; wr_data = 8'h00;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    logic [7:0] w; logic b;
    wr(8'h11, d, w, b);
  endtask

  // run lines from s0; returns number of lines with sync high
  task automatic run_frame(input logic [LW-1:0] s, input logic [3:0] e,
                           input string req, output int hi_lines);
    hi_lines = 0;
    line = s - 3;
    vs_start = s;
    for (int k = 0; k < 24; k++) begin
      logic [LW-1:0] l;
      l = s - 3 + LW'(k);
      line = l;
      if (!vs_m && l == s) begin vs_m = 1; first_m = l; end
      else if (vs_m && l != first_m && l[3:0] == e) vs_m = 0;
      repeat (4) @(negedge clk);
      check(req, {31'd0, vsync}, {31'd0, vs_m});
      if (vsync) hi_lines++;
    end
  endtask

  task automatic t_reset();
    check("R3 rd", {24'd0, rd_data}, 32'h00);
    check("R3 vsync", {31'd0, vsync}, 0);
    check("R3 pend", {31'd0, pend}, 0);
    check("R3 we", {24'd0, twe}, 0);
    sel = 1'b1; #1;
    check("R3 rd B", {24'd0, rd_data}, 32'h00);
    sel = 1'b0;
  endtask

  task automatic t_shadow();
    wr_cfg(8'hFF);
    check("R2 bit6 dropped", {24'd0, rd_data}, 32'hBF);
    sel = 1'b1; #1;
    check("R1 B untouched", {24'd0, rd_data}, 32'h00);
    wr_cfg(8'h5C);
    check("R1 B written", {24'd0, rd_data}, 32'h1C);
    sel = 1'b0; #1;
    check("R1 A kept", {24'd0, rd_data}, 32'hBF);
  endtask

  task automatic t_protect();
    logic [7:0] w; logic b;
    sel = 1'b0;
    wr_cfg(8'h90);                 // A: locked
    wr(8'h03, 8'hAA, w, b);
    check("R4 locked idx3", {24'd0, w}, 0);
    wr(8'h07, 8'h10, w, b);
    check("R4 locked idx7", {24'd0, w}, 0);
    check("R5 b4 open locked", {31'd0, b}, 1);
    sel = 1'b1;                    // B: 1Ch, unlocked
    wr(8'h02, 8'h55, w, b);
    check("R11 B unlocked idx2", {24'd0, w}, 32'h04);
    sel = 1'b0;
    wr_cfg(8'h10);                 // A unlocked
    wr(8'h03, 8'hAA, w, b);
    check("R4 open idx3", {24'd0, w}, 32'h08);
    wr(8'h07, 8'h00, w, b);
    check("R4 open idx7", {24'd0, w}, 32'h80);
    check("R5 b4 open", {31'd0, b}, 1);
    wr(8'h12, 8'h00, w, b);
    check("R4 other idx", {24'd0, w}, 0);
    check("R5 other idx", {31'd0, b}, 0);
  endtask

  task automatic t_sync_len();
    int n;
    sel = 1'b0;
    wr_cfg(8'h37);                 // off, end=7
    run_frame(11'd100, 4'd7, "R6 R7 len3", n);
    check("R7 len3", n, 3);
    wr_cfg(8'h34);                 // end = start low bits -> 16 lines
    run_frame(11'd500, 4'd4, "R7 len16", n);
    check("R7 len16", n, 16);
    wr_cfg(8'h3B);                 // end=B, start low=A -> 1 line
    run_frame(11'd250, 4'hB, "R7 len1", n);
    check("R7 len1", n, 1);
    sel = 1'b1;                    // B: end=Ch
    wr_cfg(8'h3C);
    run_frame(11'd200, 4'hC, "R11 B end", n);
    check("R11 B len", n, 4);      // 200 low=8
    sel = 1'b0;
    check("R9 pend off", {31'd0, pend}, 0);
  endtask

  task automatic t_irq();
    int n;
    sel = 1'b0;
    wr_cfg(8'h17);                 // enabled, released
    run_frame(11'd300, 4'd7, "R6 R7 irq", n);
    check("R8 set", {31'd0, pend}, 1);
    wr_cfg(8'h07);                 // clear
    @(negedge clk);
    check("R10 cleared", {31'd0, pend}, 0);
    run_frame(11'd400, 4'd7, "R6 R7 held", n);
    check("R10 held clear", {31'd0, pend}, 0);
    wr_cfg(8'h17);
    @(negedge clk);
    check("R10 release no event", {31'd0, pend}, 0);
    run_frame(11'd600, 4'd7, "R6 R7 rearm", n);
    check("R10 rearmed", {31'd0, pend}, 1);
    wr_cfg(8'h27);                 // clear with disable
    wr_cfg(8'h37);                 // disabled, released
    @(negedge clk);
    check("R9 cleared", {31'd0, pend}, 0);
    run_frame(11'd700, 4'd7, "R6 R7 dis", n);
    check("R9 blocked", {31'd0, pend}, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_shadow();
    t_protect();
    t_sync_len();
    t_irq();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule